// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block decides which of five interrupt sources an 8-bit processor core services next. The five sources are two external pins, two timer overflows and a serial port. Each source raises a request flag. The serial request is the OR of its receive flag and its transmit flag. Software programs two byte-wide registers through a small write and read port:

- A mask register, which holds one global switch and five per-source switches.
- A level register, which puts each source in the upper or the lower of two priority levels.

At each instruction boundary that the core signals, the arbiter samples the pending requests. When a request may be taken, it raises a vector request and holds it until the core acknowledges. With the request it gives the source code, the service address and the level being entered.

On acknowledge, the arbiter marks that level as in service. For timer and external sources it also pulses a clear to the request flag. The serial flags are left for the service routine to clear. When the core reports a return from interrupt, the arbiter releases the most recently entered level. From then on, requests of that level can win again.

Top module: `irq_vec_arbiter`

## Requirements
- R1: After reset both configuration registers read 0x00, `vec_req` is 0, `svc_active` is 2'b00 and `flag_clr` is 0.
- R2: `cfg_addr`=0 selects the mask register and `cfg_addr`=1 selects the level register. Mask bit 7 is the global switch. Bits 0..4 belong to external 0, timer 0, external 1, timer 1 and serial, and level bits 0..4 use the same mapping. Mask bits 5 and 6 and level bits 5..7 are not stored and read as 0.
- R3: A source can win only when its own mask bit (1 = enabled) and the global bit 7 are both 1.
- R4: Among the candidates of the chosen level, the first in the order external 0, timer 0, external 1, timer 1, serial wins. `vec_src` carries its index 0..4. `vec_addr` = 0x0003 + 8 × index.
- R5: Any pending enabled source whose level bit is 1 (upper level) wins over every lower-level source, and `vec_level` reports 1 for it.
- R6: An upper-level request is issued while only the lower level is in service.
- R7: No request is issued while the upper level is in service. A lower-level request is not issued while the lower level is in service.
- R8: The serial request is `ser_rx | ser_tx`. Acknowledging a serial vector never pulses `flag_clr`.
- R9: The cycle after an acknowledge (`vec_req` and `vec_ack` both 1), `flag_clr` is one-hot on the acknowledged external or timer source for exactly one cycle. In that same cycle, `svc_active` gains the entered level (bit 1 = upper, bit 0 = lower).
- R10: A `reti` pulse clears the upper in-service bit if it is set, otherwise the lower one. After that, requests of the released level can be issued again.
- R11: Requests are sampled only in cycles where `insn_boundary` is 1, and never in a cycle where `reti` is 1.
- R12: Once raised, `vec_req`, `vec_src` and `vec_level` stay unchanged until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = mask register, 1 = level register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| src_flag | input | 4 | Request flags: external 0, timer 0, external 1, timer 1 |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| vec_ack | input | 1 | Core accepts the vector |
| reti | input | 1 | Core finished a service routine |
| vec_req | output | 1 | Vector request to the core |
| vec_src | output | 3 | Index of the winning source |
| vec_addr | output | 16 | Service entry address |
| vec_level | output | 1 | Level being entered (1 = upper) |
| flag_clr | output | 5 | One-cycle clear pulse per source (bit 4 always 0) |
| svc_active | output | 2 | Levels in service: bit 1 upper, bit 0 lower |

## Verification
Faults in the in-service bits show up at the ports either as a vector issued when it must be blocked, or as a missing vector after `reti`. Either is visible one cycle after the next instruction boundary.

A wrong poll or level choice shows on `vec_src` and `vec_level` in the cycle right after the sampling boundary. A missing or misplaced flag clear shows on `flag_clr` in the cycle right after the acknowledge.

The bench walks a table of mask, level and flag patterns. Directed sequences then cover nesting, release order, back-to-back returns and the hold of an unacknowledged request.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned SRC_COUNT = 5;
  localparam int unsigned SRC_IDX_W = 3;

  typedef enum logic [SRC_IDX_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } src_e;

  typedef struct packed {
    logic                 found;
    logic                 lvl;
    logic [SRC_IDX_W-1:0] idx;
  } pick_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NSRC    = 5,
  parameter int unsigned GLB_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NSRC-1:0]   src_en,
  output logic              glb_en,
  output logic [NSRC-1:0]   src_hi
);
  logic [NSRC-1:0] en_q, hi_q;
  logic            glb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      hi_q  <= '0;
      glb_q <= 1'b0;
    end else if (we) begin
      if (!addr) begin
        en_q  <= wdata[NSRC-1:0];
        glb_q <= wdata[GLB_BIT];
      end else begin
        hi_q <= wdata[NSRC-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (!addr) begin
      rdata[NSRC-1:0] = en_q;
      rdata[GLB_BIT]  = glb_q;
    end else begin
      rdata[NSRC-1:0] = hi_q;
    end
  end

  assign src_en = en_q;
  assign glb_en = glb_q;
  assign src_hi = hi_q;

  AST_CFG_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (en_q == '0) && (hi_q == '0) && !glb_q); // R1
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_vec_pkg::*;
#(
  parameter int unsigned NSRC = 5
) (
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] hi,
  input  logic [1:0]      svc,
  output pick_t           pick
);
  logic [NSRC-1:0] hi_set, lo_set, use_set;
  logic            take_hi, take_lo;

  assign hi_set  = pend & hi;
  assign lo_set  = pend & ~hi;
  assign take_hi = (|hi_set) && !svc[1];
  assign take_lo = !take_hi && (|lo_set) && (svc == 2'b00);
  assign use_set = take_hi ? hi_set : lo_set;

  // First set bit in poll order: lowest index wins.
  logic [SRC_IDX_W-1:0] first_idx [NSRC+1];
  generate
    genvar g;
    assign first_idx[NSRC] = '0;
    for (g = NSRC - 1; g >= 0; g--) begin : g_poll
      assign first_idx[g] = use_set[g] ? SRC_IDX_W'(g) : first_idx[g+1];
    end
  endgenerate

  always_comb begin
    pick.found = take_hi || take_lo;
    pick.lvl   = take_hi;
    pick.idx   = first_idx[0];
  end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter,
  input  logic       enter_lvl,
  input  logic       reti,
  output logic [1:0] svc
);
  logic [1:0] svc_q, after_ret;

  always_comb begin
    after_ret = svc_q;
    if (reti) begin
      if (svc_q[1]) after_ret[1] = 1'b0;
      else          after_ret[0] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) svc_q <= 2'b00;
    else if (enter) svc_q <= after_ret | (enter_lvl ? 2'b10 : 2'b01);
    else            svc_q <= after_ret;
  end

  assign svc = svc_q;

  AST_RETI_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !enter && svc_q[1]) |=> !svc_q[1] && (svc_q[0] == $past(svc_q[0]))); // R10
  AST_ENTER_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (enter && !reti) |=> (enter_lvl ? svc_q[1] : svc_q[0]) ); // R9
endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
  import irq_vec_pkg::*;
#(
  parameter int unsigned NSRC      = SRC_COUNT,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned GLB_BIT   = 7,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned VEC_BASE  = 16'h0003,
  parameter int unsigned VEC_STEP  = 8,
  parameter int unsigned IDX_W     = SRC_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [NSRC-2:0]   src_flag,
  input  logic              ser_rx,
  input  logic              ser_tx,
  input  logic              insn_boundary,
  input  logic              vec_ack,
  input  logic              reti,
  output logic              vec_req,
  output logic [IDX_W-1:0]  vec_src,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              vec_level,
  output logic [NSRC-1:0]   flag_clr,
  output logic [1:0]        svc_active
);
  localparam int unsigned SER_IDX = NSRC - 1;

  logic [NSRC-1:0] src_en, src_hi, raw_req, pend;
  logic            glb_en;
  pick_t           pick;

  irq_cfg_regs #(.DATA_W(DATA_W), .NSRC(NSRC), .GLB_BIT(GLB_BIT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .src_en(src_en), .glb_en(glb_en), .src_hi(src_hi)
  );

  assign raw_req = {ser_rx | ser_tx, src_flag};
  assign pend    = raw_req & src_en & {NSRC{glb_en}};

  irq_pick #(.NSRC(NSRC)) u_pick (
    .pend(pend), .hi(src_hi), .svc(svc_active), .pick(pick)
  );

  logic accept, issue;
  assign accept = vec_req && vec_ack;
  assign issue  = !vec_req && insn_boundary && !reti && pick.found;

  irq_svc_track u_svc (
    .clk(clk), .rst_n(rst_n), .enter(accept), .enter_lvl(vec_level),
    .reti(reti), .svc(svc_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_req   <= 1'b0;
      vec_src   <= '0;
      vec_level <= 1'b0;
    end else if (issue) begin
      vec_req   <= 1'b1;
      vec_src   <= pick.idx;
      vec_level <= pick.lvl;
    end else if (accept) begin
      vec_req   <= 1'b0;
    end
  end

  logic [NSRC-1:0] clr_d;
  generate
    genvar s;
    for (s = 0; s < NSRC; s++) begin : g_clr
      if (s == SER_IDX) begin : g_keep
        assign clr_d[s] = 1'b0;
      end else begin : g_auto
        assign clr_d[s] = accept && (vec_src == IDX_W'(s));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) flag_clr <= '0;
    else        flag_clr <= clr_d;
  end

  assign vec_addr = ADDR_W'(VEC_BASE) + ADDR_W'(vec_src) * ADDR_W'(VEC_STEP);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && !vec_ack) |=> vec_req && $stable(vec_src) && $stable(vec_level)); // R12
  AST_NO_ISSUE_ON_RETI: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !vec_req) |=> !vec_req); // R11
  AST_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_boundary && !vec_req) |=> !vec_req); // R11
  AST_HI_NOT_PREEMPTED: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_active[1] && !vec_req) |=> !vec_req); // R7
  AST_LO_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_active[0] && !vec_req) |=> !vec_req || vec_level); // R6
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_clr) && !flag_clr[SER_IDX]); // R8
  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_clr) |=> (flag_clr == '0)); // R9
endmodule

// File: tb/irq_vec_arbiter_test.sv
module irq_vec_arbiter_test;
  localparam int unsigned CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_addr = 1'b0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic [5:0] flg = '0;
  logic       insn_boundary = 1'b0, vec_ack = 1'b0, reti = 1'b0;
  logic       vec_req, vec_level;
  logic [2:0] vec_src;
  logic [15:0] vec_addr;
  logic [4:0] flag_clr;
  logic [1:0] svc_active;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_arbiter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_flag(flg[3:0]),
    .ser_rx(flg[4]), .ser_tx(flg[5]), .insn_boundary(insn_boundary),
    .vec_ack(vec_ack), .reti(reti), .vec_req(vec_req), .vec_src(vec_src),
    .vec_addr(vec_addr), .vec_level(vec_level), .flag_clr(flag_clr),
    .svc_active(svc_active)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic boundary();
    insn_boundary = 1'b1; step(); insn_boundary = 1'b0;
  endtask

  task automatic ack();
    vec_ack = 1'b1; step(); vec_ack = 1'b0;
  endtask

  task automatic ret(input bit with_boundary);
    reti = 1'b1; insn_boundary = with_boundary; step();
    reti = 1'b0; insn_boundary = 1'b0;
  endtask

  // {en[7:0], pri[7:0], flags[5:0], exp_req, exp_src[2:0], exp_lvl}
  localparam int NV = 10;
  localparam logic [26:0] TBL [NV] = '{
    {8'h9F, 8'h00, 6'b011111, 1'b1, 3'd0, 1'b0},  // R4 poll first
    {8'h9F, 8'h00, 6'b011110, 1'b1, 3'd1, 1'b0},  // R4
    {8'h9F, 8'h04, 6'b011111, 1'b1, 3'd2, 1'b1},  // R5 upper wins
    {8'h1F, 8'h00, 6'b011111, 1'b0, 3'd0, 1'b0},  // R3 global off
    {8'h9E, 8'h00, 6'b000001, 1'b0, 3'd0, 1'b0},  // R3 own bit off
    {8'h90, 8'h00, 6'b100000, 1'b1, 3'd4, 1'b0},  // R8 tx alone
    {8'h90, 8'h10, 6'b010000, 1'b1, 3'd4, 1'b1},  // R8 rx alone upper
    {8'h9F, 8'h18, 6'b011111, 1'b1, 3'd3, 1'b1},  // R5 poll in upper
    {8'hC8, 8'h00, 6'b001000, 1'b1, 3'd3, 1'b0},  // R2 bit6 no effect
    {8'h9F, 8'h1F, 6'b001100, 1'b1, 3'd2, 1'b1}   // R4 all upper
  };

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R1 reset state
    cfg_addr = 1'b0; #1;
    chk(cfg_rdata == 8'h00, "R1 mask reset", cfg_rdata, 0);
    cfg_addr = 1'b1; #1;
    chk(cfg_rdata == 8'h00, "R1 level reset", cfg_rdata, 0);
    chk({vec_req, svc_active, flag_clr} == '0, "R1 outputs reset",
        {vec_req, svc_active, flag_clr}, 0);
    rst_n = 1'b1; step();

    // R2 register map
    wr(1'b0, 8'hFF); wr(1'b1, 8'hFF);
    cfg_addr = 1'b0; #1;
    chk(cfg_rdata == 8'h9F, "R2 mask read", cfg_rdata, 8'h9F);
    cfg_addr = 1'b1; #1;
    chk(cfg_rdata == 8'h1F, "R2 level read", cfg_rdata, 8'h1F);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [26:0] e;
      int ea;
      e = TBL[i];
      wr(1'b0, e[26:19]); wr(1'b1, e[18:11]);
      flg = e[10:5];
      boundary();
      ea = 3 + 8 * int'(e[3:1]);
      if (e[4])
        chk(vec_req && vec_src == e[3:1] && vec_level == e[0] && vec_addr == 16'(ea),
            $sformatf("R4/R5 table %0d", i), {vec_req, vec_src, vec_level, vec_addr},
            {1'b1, e[3:1], e[0], 16'(ea)});
      else
        chk(!vec_req, $sformatf("R3 table %0d", i), vec_req, 0);
      if (vec_req) begin
        ack(); flg = '0; ret(1'b0);
      end
      flg = '0; step();
    end

    // R11 no sampling without boundary
    wr(1'b0, 8'h9F); wr(1'b1, 8'h02);
    flg = 6'b000001;
    step(); step(); step();
    chk(!vec_req, "R11 no boundary", vec_req, 0);

    // R9 ext0 at lower level, then nesting
    boundary();
    chk(vec_req && vec_src == 3'd0 && !vec_level, "R4 ext0 lower", {vec_src, vec_level}, 0);
    ack();
    chk(flag_clr == 5'b00001, "R9 clear ext0", flag_clr, 5'b00001);
    chk(svc_active == 2'b01, "R9 lower in service", svc_active, 1);
    flg = 6'b000100; step();
    chk(flag_clr == 5'b00000, "R9 clear one cycle", flag_clr, 0);
    boundary();
    chk(!vec_req, "R7 equal level blocked", vec_req, 0);
    flg = 6'b000110;
    boundary();
    chk(vec_req && vec_src == 3'd1 && vec_level, "R6 upper preempts", {vec_src, vec_level}, 3);
    ack();
    chk(flag_clr == 5'b00010 && svc_active == 2'b11, "R9 timer0 clear and nest",
        {flag_clr, svc_active}, {5'b00010, 2'b11});
    flg = 6'b000100; step();
    boundary();
    chk(!vec_req, "R7 upper not preempted", vec_req, 0);
    ret(1'b1);
    chk(!vec_req, "R11 no issue on reti", vec_req, 0);
    chk(svc_active == 2'b01, "R10 upper released first", svc_active, 1);
    ret(1'b0);
    chk(svc_active == 2'b00, "R10 lower released", svc_active, 0);
    boundary();
    chk(vec_req && vec_src == 3'd2 && vec_addr == 16'h0013, "R10 lower retaken",
        vec_addr, 16'h0013);

    // R12 hold while unacknowledged
    flg = 6'b000101;
    wr(1'b1, 8'h01);
    boundary(); step(); step();
    chk(vec_req && vec_src == 3'd2 && !vec_level, "R12 request held",
        {vec_req, vec_src, vec_level}, {1'b1, 3'd2, 1'b0});
    ack(); flg = '0; step(); ret(1'b0);

    // R8 serial not cleared
    wr(1'b0, 8'h90); wr(1'b1, 8'h00);
    flg = 6'b010000;
    boundary();
    chk(vec_req && vec_src == 3'd4 && vec_addr == 16'h0023, "R8 serial vector",
        vec_addr, 16'h0023);
    ack();
    chk(flag_clr == 5'b00000, "R8 serial no clear", flag_clr, 0);
    ret(1'b0); flg = '0; step();

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule